// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects eight peripheral request lines and presents a single interrupt request to a processor. It synchronises each line and detects rising edges. Every edge is held in a pending register until the processor starts the matching routine. A software mask can hold any input back from the processor. The block picks the most important unmasked pending input. It raises its request only when that input outranks every routine still marked in service, so more important work can nest inside less important work.

When the processor pulses the acknowledge input, the block moves the winning input from pending to in-service in one cycle. On the next cycle it returns a vector number, which is a programmable base plus the input index. Software ends a routine by writing a non-specific end-of-interrupt command. The controller can run with fixed priority, where input 0 is the most important. It can also run with rotating priority, where an input that has just finished becomes the least important.

Top module: `prio_intc`

## Requirements
- R1: A rising edge on `irqIn[i]` marks input i pending. `intReq` can first be high after the third rising clock edge that follows the change of the input. An input held high produces only one request.
- R2: Configuration address 0 is the mask register, and bit i set to 1 masks input i. A masked pending input never drives `intReq`. The pending state is kept, and the request appears once the mask bit is cleared. After reset every input is masked.
- R3: An acknowledge while `intReq` is high produces `vecValid` for exactly one cycle on the next clock. In that cycle `vecOut` equals the vector base (configuration address 2) plus the index of the selected input.
- R4: The acknowledge clears the selected pending bit and sets its in-service bit in the same clock. When nothing else qualifies, `intReq` is therefore low on the cycle after the acknowledge.
- R5: In fixed mode (configuration address 1, bit 0 = 0), a lower input index wins over a higher one.
- R6: `intReq` is high only when the best candidate ranks strictly above every in-service input. A more important input preempts a running routine, while a less important input, or the same input again, is held back.
- R7: A write to configuration address 3 is a non-specific end-of-interrupt. It clears the highest-ranked in-service bit, and this can release a held-back request.
- R8: In rotating mode (address 1, bit 0 = 1), the end-of-interrupt for input k makes input k+1 (modulo 8) the highest priority and input k the lowest.
- R9: After reset `intReq` and `vecValid` are low.
- R10: An acknowledge while `intReq` is low produces no vector and changes no state.
- R11: A new edge on an input that is already in service is kept pending. It is requested again after that input's end-of-interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irqIn | input | 8 | Asynchronous peripheral request lines |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | 0 mask, 1 mode, 2 vector base, 3 end-of-interrupt |
| cfgData | input | 8 | Configuration write data |
| ackIn | input | 1 | Processor acknowledge pulse |
| intReq | output | 1 | Interrupt request to the processor |
| vecOut | output | 8 | Vector number |
| vecValid | output | 1 | Vector valid strobe |

## Verification
A request edge reaches `intReq` after three clock edges: two synchroniser flops and the pending register. The bench samples one cycle before that point and again at it. A configuration or end-of-interrupt write changes `intReq` one edge later. A vector follows its acknowledge by exactly one edge. The acknowledge task pushes each expected vector into a queue when it drives the pulse. A monitor sampling on the falling clock edge pops the queue on every `vecValid`, so a late, early, extra or missing vector each show up as a mismatch.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int IDX_W = 3;
  localparam int NUM_IN = 1 << IDX_W;

  typedef struct packed {
    logic             ackFire;
    logic [IDX_W-1:0] ackIdx;
    logic             eoiFire;
    logic [IDX_W-1:0] eoiIdx;
  } ctrlStrb_t;
endpackage

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irqIn,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  input  ctrlStrb_t         strb,
  output logic [NUM_IN-1:0] pendReg,
  output logic [NUM_IN-1:0] isrReg,
  output logic [NUM_IN-1:0] maskReg,
  output logic              rotMode,
  output logic [IDX_W-1:0]  topPtr,
  output logic [DATA_W-1:0] vecOut,
  output logic              vecValid
);
  logic [NUM_IN-1:0] syncA, syncB, lastLvl, riseHit;
  logic [NUM_IN-1:0] ackSet, eoiClr;
  logic [DATA_W-1:0] baseReg;

  assign riseHit = syncB & ~lastLvl;

  generate
    for (genvar g = 0; g < NUM_IN; g++) begin : g_bit
      assign ackSet[g] = strb.ackFire && (strb.ackIdx == IDX_W'(g));
      assign eoiClr[g] = strb.eoiFire && (strb.eoiIdx == IDX_W'(g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA    <= '0;
      syncB    <= '0;
      lastLvl  <= '0;
      pendReg  <= '0;
      isrReg   <= '0;
      maskReg  <= '1;
      rotMode  <= 1'b0;
      topPtr   <= '0;
      baseReg  <= '0;
      vecOut   <= '0;
      vecValid <= 1'b0;
    end else begin
      syncA    <= irqIn;
      syncB    <= syncA;
      lastLvl  <= syncB;
      pendReg  <= (pendReg & ~ackSet) | riseHit;
      isrReg   <= (isrReg & ~eoiClr) | ackSet;
      vecValid <= strb.ackFire;
      if (strb.ackFire) vecOut <= baseReg + DATA_W'(strb.ackIdx);
      if (strb.eoiFire && rotMode) topPtr <= strb.eoiIdx + 1'b1;
      if (cfgWe) begin
        case (cfgAddr)
          2'd0: maskReg <= cfgData[NUM_IN-1:0];
          2'd1: rotMode <= cfgData[0];
          2'd2: baseReg <= cfgData;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/intc_control.sv
module intc_control
  import intc_pkg::*;
(
  input  logic [NUM_IN-1:0] pendReg,
  input  logic [NUM_IN-1:0] isrReg,
  input  logic [NUM_IN-1:0] maskReg,
  input  logic              rotMode,
  input  logic [IDX_W-1:0]  topPtr,
  input  logic              ackIn,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  output logic              intReq,
  output ctrlStrb_t         strb
);
  logic [NUM_IN-1:0] cand;
  logic [IDX_W-1:0]  effTop, idx;
  logic [IDX_W-1:0]  candIdx, candRank, isrIdx, isrRank;
  logic              candAny, isrAny;

  assign cand   = pendReg & ~maskReg;
  assign effTop = rotMode ? topPtr : '0;

  always_comb begin
    candAny = 1'b0; candIdx = '0; candRank = '0;
    isrAny  = 1'b0; isrIdx  = '0; isrRank  = '0;
    idx     = '0;
    for (int r = NUM_IN - 1; r >= 0; r--) begin
      idx = effTop + r[IDX_W-1:0];
      if (cand[idx]) begin
        candAny = 1'b1; candIdx = idx; candRank = r[IDX_W-1:0];
      end
      if (isrReg[idx]) begin
        isrAny = 1'b1; isrIdx = idx; isrRank = r[IDX_W-1:0];
      end
    end
  end

  assign intReq       = candAny && (!isrAny || candRank < isrRank);
  assign strb.ackFire = ackIn && intReq;
  assign strb.ackIdx  = candIdx;
  assign strb.eoiFire = cfgWe && (cfgAddr == 2'd3) && isrAny;
  assign strb.eoiIdx  = isrIdx;
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irqIn,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              ackIn,
  output logic              intReq,
  output logic [DATA_W-1:0] vecOut,
  output logic              vecValid
);
  ctrlStrb_t         strb;
  logic [NUM_IN-1:0] pendReg, isrReg, maskReg;
  logic              rotMode;
  logic [IDX_W-1:0]  topPtr;

  intc_control ctrl_i (
    .pendReg(pendReg), .isrReg(isrReg), .maskReg(maskReg),
    .rotMode(rotMode), .topPtr(topPtr), .ackIn(ackIn),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .intReq(intReq), .strb(strb)
  );

  intc_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .strb(strb),
    .pendReg(pendReg), .isrReg(isrReg), .maskReg(maskReg),
    .rotMode(rotMode), .topPtr(topPtr), .vecOut(vecOut), .vecValid(vecValid)
  );
endmodule

// File: rtl/prio_intc_checker.sv
module prio_intc_checker
  import intc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ackIn,
  input logic              cfgWe,
  input logic [1:0]        cfgAddr,
  input logic              intReq,
  input logic              vecValid,
  input logic [NUM_IN-1:0] pendReg,
  input logic [NUM_IN-1:0] maskReg,
  input logic [NUM_IN-1:0] isrReg
);
  logic eoiWr, ackOk;
  assign eoiWr = cfgWe && (cfgAddr == 2'd3);
  assign ackOk = ackIn && intReq;

  // R2: a request needs an unmasked pending input
  a_r2_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    intReq |-> |(pendReg & ~maskReg));
  // R3: vector strobe follows an accepted acknowledge
  a_r3_vec_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ackOk |=> vecValid);
  // R10: no vector without an accepted acknowledge
  a_r10_no_stray_vec: assert property (@(posedge clk) disable iff (!rst_n)
    !ackOk |=> !vecValid);
  // R4: acknowledge adds one in-service bit
  a_r4_isr_grows: assert property (@(posedge clk) disable iff (!rst_n)
    ackOk && !eoiWr |=> $countones(isrReg) == $countones($past(isrReg)) + 1);
  // R7: end-of-interrupt removes one in-service bit
  a_r7_eoi_clears_one: assert property (@(posedge clk) disable iff (!rst_n)
    eoiWr && (isrReg != '0) && !ackOk |=>
      $countones(isrReg) + 1 == $countones($past(isrReg)));
endmodule

bind prio_intc prio_intc_checker chk_i (
  .clk(clk), .rst_n(rst_n), .ackIn(ackIn), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
  .intReq(intReq), .vecValid(vecValid), .pendReg(pendReg),
  .maskReg(maskReg), .isrReg(isrReg)
);

// File: tb/prio_intc_tb_top.sv
module prio_intc_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irqIn = '0;
  logic       cfgWe = 1'b0;
  logic [1:0] cfgAddr = '0;
  logic [7:0] cfgData = '0;
  logic       ackIn = 1'b0;
  logic       intReq, vecValid;
  logic [7:0] vecOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [7:0] expQ[$];

  always #5 clk = ~clk;

  prio_intc dut_i (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .ackIn(ackIn), .intReq(intReq), .vecOut(vecOut),
    .vecValid(vecValid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfgWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] bits);
    @(negedge clk);
    irqIn = irqIn | bits;
    waitN(3);
    irqIn = irqIn & ~bits;
    waitN(1);
  endtask

  // driver: pushes the expected vector when an acknowledge should be accepted
  task automatic ack(input bit expect_vec, input logic [7:0] v);
    @(negedge clk);
    ackIn = 1'b1;
    if (expect_vec) expQ.push_back(v);
    @(negedge clk);
    ackIn = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && vecValid) begin
        if (expQ.size() == 0) chk("R10 unexpected vector", int'(vecOut), -1);
        else chk("R3 vector value", int'(vecOut), int'(expQ.pop_front()));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    waitN(3);
    chk("R9 intReq at reset", intReq, 0);
    chk("R9 vecValid at reset", vecValid, 0);
    rst_n = 1'b1;
    waitN(2);
    cfgWrite(2'd2, 8'h40);

    // R2: masked input is held back but remembered
    pulse(8'h01);
    waitN(3);
    chk("R2 masked input silent", intReq, 0);
    cfgWrite(2'd0, 8'h00);
    chk("R2 request after unmask", intReq, 1);
    ack(1, 8'h40);
    chk("R4 request drops after ack", intReq, 0);
    ack(0, 8'h00);   // R10: no request, no vector
    chk("R10 no request after idle ack", intReq, 0);
    cfgWrite(2'd3, 8'h00);

    // R1: edge latency and level does not retrigger
    @(negedge clk);
    irqIn[3] = 1'b1;
    waitN(2);
    chk("R1 not yet after two edges", intReq, 0);
    waitN(1);
    chk("R1 request after three edges", intReq, 1);
    ack(1, 8'h43);
    cfgWrite(2'd3, 8'h00);
    waitN(6);
    chk("R1 held level no second request", intReq, 0);
    irqIn[3] = 1'b0;
    waitN(2);

    // R5 fixed priority, R6 nesting, R7 non-specific EOI
    pulse(8'h24);
    ack(1, 8'h42);
    chk("R6 lower input held back", intReq, 0);
    pulse(8'h02);
    chk("R6 higher input preempts", intReq, 1);
    ack(1, 8'h41);
    cfgWrite(2'd3, 8'h00);
    chk("R7 first EOI clears input 1 only", intReq, 0);
    cfgWrite(2'd3, 8'h00);
    chk("R7 second EOI releases input 5", intReq, 1);
    ack(1, 8'h45);
    cfgWrite(2'd3, 8'h00);
    chk("R5 all serviced", intReq, 0);

    // R11: same input again while in service
    pulse(8'h10);
    ack(1, 8'h44);
    pulse(8'h10);
    chk("R11 same input blocked in service", intReq, 0);
    cfgWrite(2'd3, 8'h00);
    chk("R11 re-request after EOI", intReq, 1);
    ack(1, 8'h44);
    cfgWrite(2'd3, 8'h00);

    // R8: rotating priority
    cfgWrite(2'd1, 8'h01);
    pulse(8'h44);
    ack(1, 8'h42);
    cfgWrite(2'd3, 8'h00);   // top becomes 3
    pulse(8'h02);
    ack(1, 8'h46);           // R8: 6 outranks 1
    cfgWrite(2'd3, 8'h00);   // top becomes 7
    pulse(8'h80);
    ack(1, 8'h47);           // R8: 7 outranks 1
    cfgWrite(2'd3, 8'h00);   // top becomes 0
    ack(1, 8'h41);
    cfgWrite(2'd3, 8'h00);
    chk("R8 rotation drained", intReq, 0);

    waitN(3);
    chk("R3 all expected vectors seen", expQ.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule